// File: doc/BRIEF.md
# Data Memory Overlay Address Mapper

This block sits between a processor core's data-memory port and the memories behind the lowest 8K-word window of a 14-bit data address space. A small overlay register, supplied as an input, picks where the window points. With the overlay at zero, the window is on-chip RAM, and the block raises a single-cycle internal enable. With the overlay at one or two, the window is one of two external 8K pages. In that case the block launches a registered external access whose top address bit names the page.

External accesses are stretched by a programmable wait count. The core holds its strobe and address until the block's ready output comes back high. Overlay codes above two are reserved and reach no memory. Addresses above the window belong to other decoders and are ignored here.

Top module: `dmovl_mapper`

## Requirements
- R1: While reset is held, and with no request after it, `core_rdy` is 1 and `int_en`, `ext_dsel`, `ext_rd` and `ext_wr` are 0.
- R2: With `ovl_sel` = 0 and a strobe at a window address below 8160, `int_en` and `core_rdy` are 1 in the same cycle. `int_we` equals `core_wr` and `int_addr` equals `core_addr[12:0]`.
- R3: With `ovl_sel` = 0, window addresses 8160 to 8191 raise neither `int_en` nor `ext_dsel`, and `core_rdy` stays 1.
- R4: For an external access, `ext_addr[12:0]` equals `core_addr[12:0]`. `ext_addr[13]` is 0 for `ovl_sel` = 1 and 1 for `ovl_sel` = 2.
- R5: The external select, address and strobes come from registers. They first appear the cycle after the request cycle and hold steady for N+1 cycles, where N is the wait count. `ext_rd` is raised for a read and `ext_wr` for a write. A request with both strobes high is a write.
- R6: For an external access, `core_rdy` is 0 in the request cycle and in the first N bus cycles, and 1 in the final bus cycle. N = 0 gives one bus cycle.
- R7: The wait count and overlay are captured in the request cycle. Changes to them during the access alter neither the timing nor the address, and they raise no internal enable.
- R8: Reserved overlay codes (3 and above) raise no internal or external enable, and `core_rdy` stays 1 in the request cycle.
- R9: Addresses with bit 13 set raise no enable of this block, and `core_rdy` stays 1.
- R10: With neither strobe high, no enable is raised and `core_rdy` is 1.
- R11: A new request presented in the cycle after an external access completes is accepted at once, whether it is internal or external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_addr | input | 14 | Core data address |
| core_rd | input | 1 | Core read strobe, held until ready |
| core_wr | input | 1 | Core write strobe, held until ready |
| ovl_sel | input | 4 | Overlay register value |
| dwait | input | 3 | External wait-state count N |
| int_en | output | 1 | On-chip RAM enable |
| int_we | output | 1 | On-chip RAM write enable |
| int_addr | output | 13 | On-chip RAM word address |
| ext_addr | output | 14 | External address bus |
| ext_dsel | output | 1 | External data-memory select, active high |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| core_rdy | output | 1 | Access completes this cycle; low stalls the core |

## Verification
Internal enables, reserved-code and out-of-window responses, and `core_rdy` for the request cycle are all due in that same cycle, because they are combinational from the inputs. External select, address and strobes are due one clock edge after the request. `core_rdy` then rises N edges later, in the last bus cycle, and the select drops at the edge after that. The bench drives inputs just after the rising edge and compares every output at the falling edge against a behavioural model. That model advances its remaining-wait counter once per compared cycle, so each expected value lands in exactly the cycle the requirements name.

// File: rtl/dmovl_pkg.sv
package dmovl_pkg;

    // Destination of the access presented this cycle
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_INT  = 2'd1,
        TGT_EXT  = 2'd2
    } tgt_e;

    // External bus sequencer state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } bus_st_e;

endpackage

// File: rtl/dmovl_decode.sv
module dmovl_decode
    import dmovl_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int OVL_W     = 4,
    parameter int INT_WORDS = 8160
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [OVL_W-1:0]  ovl,
    input  logic              req,
    output tgt_e              tgt,
    output logic              page_hi
);
    localparam logic [ADDR_W-1:0] INT_LIMIT = ADDR_W'(INT_WORDS);

    logic in_win;

    always_comb begin
        in_win  = (addr[ADDR_W-1] == 1'b0);
        tgt     = TGT_NONE;
        page_hi = 1'b0;
        if (req && in_win) begin
            if (ovl == OVL_W'(0)) begin
                if (addr < INT_LIMIT) begin
                    tgt = TGT_INT;
                end
            end else if (ovl == OVL_W'(1)) begin
                tgt     = TGT_EXT;
                page_hi = 1'b0;
            end else if (ovl == OVL_W'(2)) begin
                tgt     = TGT_EXT;
                page_hi = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmovl_wait_ctr.sv
module dmovl_wait_ctr #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [WAIT_W-1:0] wait_in,
    output logic              last
);
    logic [WAIT_W-1:0] cnt_d;
    logic [WAIT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = wait_in;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - WAIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/dmovl_ext_drv.sv
module dmovl_ext_drv
    import dmovl_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic              start_page,
    input  logic [ADDR_W-2:0] start_addr,
    input  logic              last,
    output logic              busy,
    output logic              sel,
    output logic              rd,
    output logic              wr,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        bus_st_e           st;
        logic              sel;
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } drv_t;

    drv_t drv_d;
    drv_t drv_q;

    always_comb begin
        drv_d = drv_q;
        case (drv_q.st)
            ST_IDLE: begin
                if (start) begin
                    drv_d.st   = ST_BUS;
                    drv_d.sel  = 1'b1;
                    drv_d.rd   = !start_wr;
                    drv_d.wr   = start_wr;
                    drv_d.addr = {start_page, start_addr};
                end
            end
            ST_BUS: begin
                if (last) begin
                    drv_d.st  = ST_IDLE;
                    drv_d.sel = 1'b0;
                    drv_d.rd  = 1'b0;
                    drv_d.wr  = 1'b0;
                end
            end
            default: drv_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign busy = (drv_q.st == ST_BUS);
    assign sel  = drv_q.sel;
    assign rd   = drv_q.rd;
    assign wr   = drv_q.wr;
    assign addr = drv_q.addr;

endmodule

// File: rtl/dmovl_mapper.sv
module dmovl_mapper
    import dmovl_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int OVL_W     = 4,
    parameter int WAIT_W    = 3,
    parameter int INT_WORDS = 8160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_rd,
    input  logic              core_wr,
    input  logic [OVL_W-1:0]  ovl_sel,
    input  logic [WAIT_W-1:0] dwait,
    output logic              int_en,
    output logic              int_we,
    output logic [ADDR_W-2:0] int_addr,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_dsel,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic              core_rdy
);
    localparam int WIN_W = ADDR_W - 1;

    tgt_e tgt;
    logic page_hi;
    logic req;
    logic busy;
    logic last;
    logic start;

    assign req = core_rd | core_wr;

    dmovl_decode #(
        .ADDR_W   (ADDR_W),
        .OVL_W    (OVL_W),
        .INT_WORDS(INT_WORDS)
    ) dec_i (
        .addr   (core_addr),
        .ovl    (ovl_sel),
        .req    (req),
        .tgt    (tgt),
        .page_hi(page_hi)
    );

    assign start = !busy && (tgt == TGT_EXT);

    dmovl_wait_ctr #(
        .WAIT_W(WAIT_W)
    ) ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .run    (busy),
        .wait_in(dwait),
        .last   (last)
    );

    dmovl_ext_drv #(
        .ADDR_W(ADDR_W)
    ) drv_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_wr  (core_wr),
        .start_page(page_hi),
        .start_addr(core_addr[WIN_W-1:0]),
        .last      (last),
        .busy      (busy),
        .sel       (ext_dsel),
        .rd        (ext_rd),
        .wr        (ext_wr),
        .addr      (ext_addr)
    );

    always_comb begin
        int_en   = !busy && (tgt == TGT_INT);
        int_we   = int_en && core_wr;
        int_addr = core_addr[WIN_W-1:0];
        if (busy) begin
            core_rdy = last;
        end else begin
            core_rdy = (tgt != TGT_EXT);
        end
    end

endmodule

// File: rtl/dmovl_mapper_chk.sv
module dmovl_mapper_chk #(
    parameter int ADDR_W    = 14,
    parameter int OVL_W     = 4,
    parameter int WAIT_W    = 3,
    parameter int INT_WORDS = 8160
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] core_addr,
    input logic              core_rd,
    input logic              core_wr,
    input logic [OVL_W-1:0]  ovl_sel,
    input logic              int_en,
    input logic [ADDR_W-2:0] int_addr,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ext_dsel,
    input logic              ext_rd,
    input logic              ext_wr,
    input logic              core_rdy
);
    // R2
    int_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_en |-> core_rdy);

    // R3
    int_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_en |-> (int_addr < (ADDR_W-1)'(INT_WORDS)));

    // R5
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_en && ext_dsel));

    // R5
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_dsel && !core_rdy) |=> (ext_dsel && $stable(ext_addr) && $stable(ext_wr)));

    // R5
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd || ext_wr) |-> (ext_dsel && $onehot0({ext_rd, ext_wr})));

    // R6
    sel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_dsel && core_rdy) |=> !ext_dsel);

    // R4
    page_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_dsel) |-> (ext_addr[ADDR_W-1] == ($past(ovl_sel) == OVL_W'(2))));

    // R8
    rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_dsel && (core_rd || core_wr) && !core_addr[ADDR_W-1] && (ovl_sel > OVL_W'(2)))
        |-> (core_rdy && !int_en));

    // R9
    outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_dsel && core_addr[ADDR_W-1]) |-> (core_rdy && !int_en));

endmodule

bind dmovl_mapper dmovl_mapper_chk #(
    .ADDR_W   (ADDR_W),
    .OVL_W    (OVL_W),
    .WAIT_W   (WAIT_W),
    .INT_WORDS(INT_WORDS)
) chk_i (.*);

// File: tb/dmovl_mapper_tb.sv
module dmovl_mapper_tb_top;
    localparam int ADDR_W = 14;
    localparam int OVL_W  = 4;
    localparam int WAIT_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] core_addr = '0;
    logic              core_rd = 1'b0;
    logic              core_wr = 1'b0;
    logic [OVL_W-1:0]  ovl_sel = '0;
    logic [WAIT_W-1:0] dwait = '0;
    logic              int_en;
    logic              int_we;
    logic [ADDR_W-2:0] int_addr;
    logic [ADDR_W-1:0] ext_addr;
    logic              ext_dsel;
    logic              ext_rd;
    logic              ext_wr;
    logic              core_rdy;

    dmovl_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .core_rd(core_rd),
        .core_wr(core_wr), .ovl_sel(ovl_sel), .dwait(dwait), .int_en(int_en),
        .int_we(int_we), .int_addr(int_addr), .ext_addr(ext_addr),
        .ext_dsel(ext_dsel), .ext_rd(ext_rd), .ext_wr(ext_wr), .core_rdy(core_rdy)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // reference model state
    bit m_busy = 1'b0;
    int m_rem = 0;
    int m_addr = 0;
    bit m_wr = 1'b0;
    bit last_rdy = 1'b1;

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // per-cycle model compare at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                int a;
                bit rq;
                bit e_int, e_sel, e_rd, e_wr, e_rdy;
                int e_ea;
                a = int'(core_addr);
                rq = core_rd || core_wr;
                e_int = 0; e_sel = 0; e_rd = 0; e_wr = 0; e_rdy = 1; e_ea = 0;
                if (m_busy) begin
                    e_sel = 1; e_ea = m_addr; e_wr = m_wr; e_rd = !m_wr;
                    e_rdy = (m_rem == 0);
                    if (m_rem == 0) m_busy = 0;
                    else m_rem--;
                end else if (rq && a < 8192) begin
                    if (ovl_sel == 0) begin
                        e_int = (a < 8160);
                    end else if (ovl_sel == 1 || ovl_sel == 2) begin
                        e_rdy = 0;
                        m_busy = 1;
                        m_rem = int'(dwait);
                        m_addr = ((ovl_sel == 2) ? 8192 : 0) + a;
                        m_wr = core_wr;
                    end
                end
                chk("core_rdy", int'(core_rdy), int'(e_rdy));
                chk("int_en", int'(int_en), int'(e_int));
                if (e_int) begin
                    chk("int_we", int'(int_we), int'(core_wr));
                    chk("int_addr", int'(int_addr), a % 8192);
                end
                chk("ext_dsel", int'(ext_dsel), int'(e_sel));
                chk("ext_rd", int'(ext_rd), int'(e_rd));
                chk("ext_wr", int'(ext_wr), int'(e_wr));
                if (e_sel) chk("ext_addr", int'(ext_addr), e_ea);
                last_rdy = e_rdy;
            end
        end
    end

    // one access, held until ready; optionally perturb wait/overlay (R7)
    task automatic access(string t, int addr, bit rd, bit wr, int ovl, int wt, bit perturb);
        tag = t;
        core_addr = ADDR_W'(addr);
        core_rd = rd;
        core_wr = wr;
        ovl_sel = OVL_W'(ovl);
        dwait = WAIT_W'(wt);
        @(posedge clk);
        if (perturb) begin
            #1;
            ovl_sel = '0;
            dwait = '0;
        end
        while (!last_rdy) @(posedge clk);
        #1;
    endtask

    task automatic idle(string t, int n);
        tag = t;
        core_rd = 0;
        core_wr = 0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R1";
        chk("core_rdy", int'(core_rdy), 1);
        chk("int_en", int'(int_en), 0);
        chk("ext_dsel", int'(ext_dsel), 0);
        chk("ext_rd", int'(ext_rd), 0);
        chk("ext_wr", int'(ext_wr), 0);
        @(posedge clk);
        #1;
        rst_n = 1;
        idle("R1", 2);
        // R10: strobes low, overlay and address varied
        ovl_sel = 4'd1; core_addr = 14'h0100;
        idle("R10", 3);
        // R2: internal accesses
        access("R2", 16'h0000, 1, 0, 0, 5, 0);
        access("R2", 16'h1FDF, 0, 1, 0, 5, 0);
        access("R2", 16'h0ABC, 1, 0, 0, 0, 0);
        // R3: reserved top of internal window
        access("R3", 16'h1FE0, 1, 0, 0, 0, 0);
        access("R3", 16'h1FFF, 0, 1, 0, 0, 0);
        idle("R10", 1);
        // R4 / R6: external pages and wait counts
        access("R4", 16'h1234, 1, 0, 1, 0, 0);
        idle("R6", 1);
        access("R6", 16'h0001, 0, 1, 2, 3, 0);
        idle("R6", 1);
        access("R4", 16'h1FFF, 1, 0, 2, 7, 0);
        idle("R4", 1);
        access("R6", 16'h1FFF, 0, 1, 1, 1, 0);
        idle("R6", 1);
        // R5: both strobes means write
        access("R5", 16'h0555, 1, 1, 1, 2, 0);
        idle("R5", 1);
        // R7: overlay and wait changed mid-access
        access("R7", 16'h0042, 1, 0, 2, 5, 1);
        idle("R7", 1);
        // R8: reserved overlay codes
        access("R8", 16'h0010, 0, 1, 3, 2, 0);
        access("R8", 16'h0020, 1, 0, 7, 2, 0);
        access("R8", 16'h1FFF, 0, 1, 15, 2, 0);
        // R9: above the window
        access("R9", 16'h2000, 1, 0, 1, 4, 0);
        access("R9", 16'h3FFF, 0, 1, 0, 4, 0);
        access("R9", 16'h2ABC, 1, 0, 2, 4, 0);
        // R11: back-to-back
        access("R11", 16'h0100, 1, 0, 1, 0, 0);
        access("R11", 16'h0200, 0, 1, 2, 0, 0);
        access("R11", 16'h0300, 1, 0, 0, 0, 0);
        access("R11", 16'h0400, 0, 1, 1, 2, 0);
        idle("R10", 3);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule